// File: doc/BRIEF.md
# Oscillator Loss Detector with Internal Fallback

This block watches an external oscillator and reports when it stops toggling. A slow sample clock is built by dividing a low-frequency reference clock by `DIV_RATIO`, which is 64 by default. With a 31 kHz reference this gives a period of about 2 ms. Every falling edge of the external clock toggles a flip-flop in the external domain. That toggle is carried into the reference domain by a synchronizer and arrives there as an activity pulse. The activity pulse sets a latch, and each rising edge of the sample clock clears it. A fault is declared when the whole high half of a sample period passes and the latch is still clear, which means no external falling edge arrived in that half.

When a fault is declared, the block raises the clock-fail indication and steers the clock-select output to the internal high-frequency source. It also sets a sticky oscillator-fail flag, which drives an interrupt request when that interrupt is enabled. The fallback stays in place until one of the clear events happens: reset, sleep entry, or a firmware reselect. After a reselect, the clock select stays on the internal source until the start-up timer reports done. At that point monitoring restarts, and a clock that is still dead is flagged again. Detection is held off for one full sample period after reset, after enable and after every clear, so the first check never falls inside a partial window.

Top module: `fail_safe_clk_mon`

## Requirements
- R1: While reset is held, and at the first sample after reset is released, `clk_fail_o`, `int_sel_o`, `osc_fail_flag_o` and `irq_o` are all 0. A `int_sel_o` value of 0 selects the external clock.
- R2: An external clock that shows a falling edge more often than every `DIV_RATIO/2` reference cycles never causes a fault.
- R3: A stopped external clock, stuck high or stuck low, or one that is too slow, causes a fault. At a fault, `clk_fail_o`, `int_sel_o` (1 = internal source) and `osc_fail_flag_o` all rise on the same reference edge. From the moment the clock stops, this happens no sooner than `DIV_RATIO/2` and no later than `2*DIV_RATIO+6` reference cycles.
- R4: After enable or after a clear, the first fault comes `DIV_RATIO + DIV_RATIO/2` reference cycles later, within a tolerance of one to two cycles. It never comes earlier.
- R5: While `en_i` is 0, no fault is declared.
- R6: `clk_fail_o` and `int_sel_o` stay set until a clear event occurs. A pulse on `reselect_i` while no fault is present has no effect.
- R7: A `reselect_i` pulse during a fault drops `clk_fail_o` on the next edge, but `int_sel_o` stays at 1. A later `ost_done_i` pulse returns `int_sel_o` to 0 and restarts monitoring. If the clock is still dead, the fault is flagged again.
- R8: A `sleep_i` pulse clears `clk_fail_o` and `int_sel_o` on the next edge.
- R9: `osc_fail_flag_o` is set by every fault. It is cleared only by a `flag_clr_i` pulse or by reset; a clear event does not clear it. If a set and a clear happen on the same edge, the set wins.
- R10: `irq_o` is 1 exactly when both `osc_fail_flag_o` and `irq_en_i` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| ref_clk_i | input | 1 | Low-frequency reference clock; all decision logic runs on it |
| ext_clk_i | input | 1 | External oscillator under watch |
| en_i | input | 1 | Monitor enable |
| irq_en_i | input | 1 | Interrupt enable for the fail flag |
| reselect_i | input | 1 | Firmware strobe that requests a switch back to the external source |
| sleep_i | input | 1 | Sleep entry strobe |
| ost_done_i | input | 1 | Start-up timer has expired |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the fail flag |
| clk_fail_o | output | 1 | Fault currently latched |
| int_sel_o | output | 1 | Clock select: 1 selects the internal high-frequency source |
| osc_fail_flag_o | output | 1 | Sticky oscillator-fail flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with `DIV_RATIO` set to 8 and `SYNC_STAGES` set to 2. This makes a sample half-period only four reference cycles long. With that setting, the holdoff window, a stalled clock, a too-slow clock and the recovery after reselect can each be run through several times within a few hundred cycles. It also lets the holdoff latency be checked against an exact count of reference cycles.

// File: rtl/fscm_pkg.sv
package fscm_pkg;
  typedef enum logic [1:0] {
    ST_MON     = 2'd0,
    ST_FAULT   = 2'd1,
    ST_WAIT_SU = 2'd2
  } fscm_state_e;
endpackage

// File: rtl/fscm_edge_sync.sv
module fscm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic ref_clk_i,
  output logic act_o
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic               tgl_q;
  logic [CHAIN_W-1:0] chain_q;

  // toggles on every falling edge of the watched clock
  always_ff @(negedge ext_clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  // last stage is the previous value for change detection
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[CHAIN_W-2:0], tgl_q};
  end

  assign act_o = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];
endmodule

// File: rtl/fscm_sample_div.sv
module fscm_sample_div #(
  parameter int DIV_RATIO = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int              CNT_W     = $clog2(DIV_RATIO);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(DIV_RATIO - 1);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(DIV_RATIO / 2 - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // rise_o: last cycle of a period; fall_o: last cycle of the high half
  assign rise_o = !restart_i && (cnt_q == LAST);
  assign fall_o = !restart_i && (cnt_q == HALF_END);
endmodule

// File: rtl/fscm_window.sv
module fscm_window (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic act_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic miss_o
);
  logic seen_q;
  logic armed_q;

  // activity latch: set by edges, cleared at sample rising edge; set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= 1'b0;
    else if (restart_i) seen_q <= 1'b0;
    else if (act_i)     seen_q <= 1'b1;
    else if (rise_i)    seen_q <= 1'b0;
  end

  // holdoff: armed only after one complete sample period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (restart_i) armed_q <= 1'b0;
    else if (rise_i)    armed_q <= 1'b1;
  end

  assign miss_o = armed_q && fall_i && !(seen_q || act_i);
endmodule

// File: rtl/fscm_ctrl.sv
module fscm_ctrl
  import fscm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic miss_i,
  input  logic reselect_i,
  input  logic sleep_i,
  input  logic ost_done_i,
  input  logic flag_clr_i,
  output logic restart_o,
  output logic fail_o,
  output logic int_sel_o,
  output logic flag_o
);
  fscm_state_e state_q, state_d;
  logic        fault_evt;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_MON:     if (en_i && miss_i) state_d = ST_FAULT;
      ST_FAULT:   if (reselect_i)     state_d = ST_WAIT_SU;
      ST_WAIT_SU: if (ost_done_i)     state_d = ST_MON;
      default:                        state_d = ST_MON;
    endcase
    if (sleep_i) state_d = ST_MON;
  end

  assign fault_evt = (state_q == ST_MON) && (state_d == ST_FAULT);
  assign restart_o = !en_i || sleep_i || (state_q != ST_MON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_MON;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (fault_evt)  flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end

  assign fail_o    = (state_q == ST_FAULT);
  assign int_sel_o = (state_q != ST_MON);
endmodule

// File: rtl/fail_safe_clk_mon.sv
module fail_safe_clk_mon #(
  parameter int DIV_RATIO   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic ext_clk_i,
  input  logic en_i,
  input  logic irq_en_i,
  input  logic reselect_i,
  input  logic sleep_i,
  input  logic ost_done_i,
  input  logic flag_clr_i,
  output logic clk_fail_o,
  output logic int_sel_o,
  output logic osc_fail_flag_o,
  output logic irq_o
);
  logic act, rise, fall, miss, restart;

  fscm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .rst_ni(rst_ni), .ext_clk_i(ext_clk_i), .ref_clk_i(ref_clk_i), .act_o(act)
  );

  fscm_sample_div #(.DIV_RATIO(DIV_RATIO)) i_div (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .restart_i(restart),
    .rise_o(rise), .fall_o(fall)
  );

  fscm_window i_win (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .restart_i(restart), .act_i(act),
    .rise_i(rise), .fall_i(fall), .miss_o(miss)
  );

  fscm_ctrl i_ctrl (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .en_i(en_i), .miss_i(miss),
    .reselect_i(reselect_i), .sleep_i(sleep_i), .ost_done_i(ost_done_i),
    .flag_clr_i(flag_clr_i), .restart_o(restart), .fail_o(clk_fail_o),
    .int_sel_o(int_sel_o), .flag_o(osc_fail_flag_o)
  );

  assign irq_o = osc_fail_flag_o & irq_en_i;
endmodule

// File: rtl/fscm_checker.sv
module fscm_checker (
  input logic rst_ni,
  input logic ref_clk_i,
  input logic en_i,
  input logic reselect_i,
  input logic sleep_i,
  input logic ost_done_i,
  input logic flag_clr_i,
  input logic clk_fail_o,
  input logic int_sel_o,
  input logic osc_fail_flag_o,
  input logic irq_o
);
  AST_FAULT_SETS_FLAG: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(clk_fail_o) |-> osc_fail_flag_o); // R3
  AST_FAULT_ON_INTERNAL: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    clk_fail_o |-> int_sel_o); // R3
  AST_NO_FAULT_DISABLED: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(clk_fail_o) |-> $past(en_i)); // R5
  AST_FAULT_STICKY: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(clk_fail_o) |-> $past(reselect_i || sleep_i)); // R6
  AST_SEL_RETURN: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(int_sel_o) |-> $past(ost_done_i || sleep_i)); // R7
  AST_FLAG_STICKY: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(osc_fail_flag_o) |-> $past(flag_clr_i)); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    irq_o |-> osc_fail_flag_o); // R10
endmodule

bind fail_safe_clk_mon fscm_checker i_fscm_checker (.*);

// File: tb/test_fail_safe_clk_mon.sv
module test_fail_safe_clk_mon;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  typedef struct {
    logic [3:0] vec;   // {irq, flag, int_sel, fail}
    string      req;
  } exp_t;

  logic rst_ni = 1'b0, ref_clk = 1'b0, ext_clk = 1'b0;
  logic en = 0, irq_en = 0, reselect = 0, sleep_s = 0, ost_done = 0, flag_clr = 0;
  logic clk_fail, int_sel, flag, irq;
  logic ext_run = 1'b1, ext_idle = 1'b1;
  int   ext_half = 12;
  int   n_chk = 0, n_bad = 0;
  bit   mon_on = 0;
  logic [3:0] prev_vec;
  exp_t exp_q[$];

  fail_safe_clk_mon #(.DIV_RATIO(DIV), .SYNC_STAGES(2)) i_fail_safe_clk_mon (
    .rst_ni(rst_ni), .ref_clk_i(ref_clk), .ext_clk_i(ext_clk), .en_i(en),
    .irq_en_i(irq_en), .reselect_i(reselect), .sleep_i(sleep_s),
    .ost_done_i(ost_done), .flag_clr_i(flag_clr), .clk_fail_o(clk_fail),
    .int_sel_o(int_sel), .osc_fail_flag_o(flag), .irq_o(irq)
  );

  always #4 ref_clk = ~ref_clk;

  always begin
    #(ext_half);
    if (ext_run) ext_clk = ~ext_clk;
    else         ext_clk = ext_idle;
  end

  function automatic logic [3:0] cur_vec();
    return {irq, flag, int_sel, clk_fail};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic push(logic [3:0] v, string req);
    exp_t e;
    e.vec = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic wait_fault(output int lat);
    lat = 0;
    while (clk_fail !== 1'b1 && lat < 300) begin
      @(negedge ref_clk);
      lat++;
    end
    if (clk_fail !== 1'b1) lat = 999;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // scoreboard monitor: every output change must match the next expected item
  always @(negedge ref_clk) begin
    if (mon_on && cur_vec() !== prev_vec) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected change: actual %b expected %b", cur_vec(), prev_vec);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (cur_vec() !== e.vec) begin
          n_bad++;
          $display("FAIL %s: actual %b expected %b", e.req, cur_vec(), e.vec);
        end
      end
      prev_vec = cur_vec();
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge ref_clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        summary();
      end
    end
  end

  initial begin
    int lat;
    step(3);
    chk("R1 reset outputs", int'(cur_vec()), 0);
    rst_ni = 1'b1;
    @(negedge ref_clk);
    chk("R1 after release", int'(cur_vec()), 0);
    prev_vec = cur_vec();
    mon_on = 1;

    step();
    en = 1;
    step(60);
    chk("R2 running clock, no fault", int'(clk_fail), 0);

    reselect = 1; step(); reselect = 0;
    step(20);
    chk("R6 reselect ignored without fault", int'(int_sel), 0);

    push(4'b0111, "R3 stuck-high fault");
    ext_run = 0;
    wait_fault(lat);
    chk_rng("R3 stuck-high latency", lat, HALF, 2 * DIV + 6);
    step(30);
    chk("R6 fault sticky", int'(clk_fail), 1);
    chk("R6 select sticky", int'(int_sel), 1);

    push(4'b1111, "R10 irq enable");
    irq_en = 1; step();
    @(negedge ref_clk);
    chk("R10 irq", int'(irq), 1);

    push(4'b1110, "R7 reselect drops fail keeps select");
    reselect = 1; step(); reselect = 0;
    step(10);
    chk("R9 flag survives reselect", int'(flag), 1);

    push(4'b1100, "R7 start-up done returns select");
    push(4'b1111, "R7 dead clock flagged again");
    ost_done = 1; step(); ost_done = 0;
    wait_fault(lat);
    chk_rng("R4 holdoff after clear", lat, DIV + HALF - 1, DIV + HALF + 2);

    push(4'b0011, "R9 flag clear strobe");
    flag_clr = 1; step(); flag_clr = 0;
    step(5);
    chk("R9 fault stays after flag clear", int'(clk_fail), 1);

    ext_half = 12;
    ext_run = 1;
    push(4'b0000, "R8 sleep clears fault");
    sleep_s = 1; step(); sleep_s = 0;
    step(60);
    chk("R2 no fault after sleep with live clock", int'(clk_fail), 0);

    push(4'b1111, "R3 slow clock fault");
    ext_half = 100;
    wait_fault(lat);
    chk("R3 slow clock detected", int'(lat != 999), 1);

    en = 0; step();
    push(4'b1100, "R8 sleep clears fault, flag kept");
    sleep_s = 1; step(); sleep_s = 0;
    ext_idle = 0;
    ext_run = 0;
    step(60);
    chk("R5 disabled, no fault", int'(clk_fail), 0);

    push(4'b1111, "R4 fault after enable holdoff");
    en = 1; step(0);
    wait_fault(lat);
    chk_rng("R4 holdoff after enable", lat, DIV + HALF - 1, DIV + HALF + 2);

    push(4'b0000, "R1 reset clears all");
    en = 0;
    rst_ni = 0;
    step(3);
    chk("R1 reset mid-fault", int'(cur_vec()), 0);
    rst_ni = 1;
    step(10);
    chk("R1 queue drained", exp_q.size(), 0);
    summary();
  end
endmodule